// File: doc/BRIEF.md
# CHERI Fault Information Reporter

This block sits on the trap path of a core with capability hardware. On every trap it picks which of three second trap-value registers (machine, supervisor, virtual supervisor) receives the trap's extra information. It also works out the value to write: a packed class/violation pair for a capability fault, a small combined code for a page fault, and zero for anything else.

The three registers live inside the block. Software reaches them through a simple CSR read/write port that decodes the CSR address. A trap and a software write may arrive in the same cycle. Only the register selected by the trap's target mode is written by a trap, and the other two keep their contents.

Top module: `cheri_finfo_top`

## Requirements
- R1: A trap with target mode code 0 (machine) raises `m_we` only, and the machine register takes `info_wdata` at the next clock edge.
- R2: A trap with target mode code 1 (hypervisor-supervisor or supervisor) raises `s_we` only, and only the supervisor register is updated.
- R3: A trap with target mode code 2 (virtual supervisor) raises `vs_we` only. Mode code 3 raises no write enable, and no register changes.
- R4: For exception class code 1 (capability fault), `info_wdata` carries the violation code in bits [3:0] and the fault class code in bits [19:16], with every other bit zero.
- R5: For exception class code 2 (page fault), `info_wdata` is 0 when only the normal page fault flag is set, 1 when only the capability page-table flag is set, and 2 when both are set.
- R6: For exception class codes 0 and 3 (any other exception), `info_wdata` is zero and the selected register is cleared.
- R7: A register that is neither selected by a trap nor addressed by a software write keeps its value.
- R8: A software write with `csr_we` to address `0x34B`, `0x14B` or `0x24B` stores the full `csr_wdata` into the machine, supervisor or virtual-supervisor register respectively. `csr_rdata` returns the addressed register combinationally, and it returns zero for any other address.
- R9: When a trap and a software write hit the same register in the same cycle, the trap value is stored.
- R10: All three registers and all write enables are zero in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_mode | input | 2 | Target mode: 0 machine, 1 supervisor, 2 virtual supervisor |
| exc_class | input | 2 | 0 other, 1 capability fault, 2 page fault |
| flt_type | input | 4 | Capability fault class code |
| flt_cause | input | 4 | Capability violation code |
| pf_normal | input | 1 | Normal page fault detected |
| pf_pte | input | 1 | Capability page-table fault detected |
| csr_we | input | 1 | Software CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Read data for `csr_addr` |
| m_we | output | 1 | Trap write to machine register |
| s_we | output | 1 | Trap write to supervisor register |
| vs_we | output | 1 | Trap write to virtual-supervisor register |
| info_wdata | output | XLEN | Value written on a trap |
| m_info | output | XLEN | Machine register contents |
| s_info | output | XLEN | Supervisor register contents |
| vs_info | output | XLEN | Virtual-supervisor register contents |

## Verification
Capability faults use asymmetric fault class and violation codes, so a swapped or shifted field shows up as a wrong value. Page faults are tried with each flag alone and with both flags set, which separates the 0, 1 and 2 codes. A non-capability trap is aimed at a register already holding a nonzero value, so a missing clear is visible, and mode code 3 shows that no register is touched. Software writes are issued alone, to a different register than a same-cycle trap, and to the same register as the trap, which separates the routing from the write priority.

// File: rtl/frr_pkg.sv
package frr_pkg;
  localparam int NSLOT     = 3;
  localparam int CAUSE_LSB = 0;
  localparam int TYPE_LSB  = 16;
  localparam int FIELD_W   = 4;
  localparam int PACK_W    = TYPE_LSB + FIELD_W;

  typedef enum logic [1:0] {
    TGT_M    = 2'd0,
    TGT_S    = 2'd1,
    TGT_VS   = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_CAP   = 2'd1,
    CLS_PAGE  = 2'd2,
    CLS_RSVD  = 2'd3
  } cls_e;

  // combined page fault code: both kinds -> 2, table-only -> 1, else 0
  function automatic logic [1:0] pf_code(input logic normal, input logic pte);
    if (normal && pte) return 2'd2;
    else if (pte)      return 2'd1;
    else               return 2'd0;
  endfunction

  function automatic logic [PACK_W-1:0] cap_pack(input logic [FIELD_W-1:0] ftype,
                                                 input logic [FIELD_W-1:0] fcause);
    logic [PACK_W-1:0] v;
    v = '0;
    v[TYPE_LSB +: FIELD_W]  = ftype;
    v[CAUSE_LSB +: FIELD_W] = fcause;
    return v;
  endfunction
endpackage

// File: rtl/frr_encode.sv
module frr_encode
  import frr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]         exc_class,
  input  logic [FIELD_W-1:0] flt_type,
  input  logic [FIELD_W-1:0] flt_cause,
  input  logic               pf_normal,
  input  logic               pf_pte,
  output logic [XLEN-1:0]    value
);
  localparam int PAD_CAP = XLEN - PACK_W;
  localparam int PAD_PF  = XLEN - 2;

  always_comb begin
    unique case (cls_e'(exc_class))
      CLS_CAP:  value = {{PAD_CAP{1'b0}}, cap_pack(flt_type, flt_cause)};
      CLS_PAGE: value = {{PAD_PF{1'b0}}, pf_code(pf_normal, pf_pte)};
      default:  value = '0;
    endcase
  end
endmodule

// File: rtl/frr_route.sv
module frr_route
  import frr_pkg::*;
#(
  parameter logic [11:0] ADDR_M  = 12'h34B,
  parameter logic [11:0] ADDR_S  = 12'h14B,
  parameter logic [11:0] ADDR_VS = 12'h24B
) (
  input  logic              trap_valid,
  input  logic [1:0]        trap_mode,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  output logic [NSLOT-1:0]  trap_sel,
  output logic [NSLOT-1:0]  addr_hit,
  output logic [NSLOT-1:0]  sw_sel
);
  always_comb begin
    trap_sel = '0;
    if (trap_valid) begin
      unique case (tgt_e'(trap_mode))
        TGT_M:   trap_sel[0] = 1'b1;
        TGT_S:   trap_sel[1] = 1'b1;
        TGT_VS:  trap_sel[2] = 1'b1;
        default: trap_sel    = '0;
      endcase
    end
  end

  assign addr_hit = {csr_addr == ADDR_VS, csr_addr == ADDR_S, csr_addr == ADDR_M};
  assign sw_sel   = csr_we ? addr_hit : '0;
endmodule

// File: rtl/frr_slot.sv
module frr_slot #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_we,
  input  logic [XLEN-1:0] trap_data,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_data,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (trap_we) q <= trap_data;
    else if (sw_we)   q <= sw_data;
  end
endmodule

// File: rtl/cheri_finfo_top.sv
module cheri_finfo_top
  import frr_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [11:0] ADDR_M  = 12'h34B,
  parameter logic [11:0] ADDR_S  = 12'h14B,
  parameter logic [11:0] ADDR_VS = 12'h24B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [1:0]      trap_mode,
  input  logic [1:0]      exc_class,
  input  logic [3:0]      flt_type,
  input  logic [3:0]      flt_cause,
  input  logic            pf_normal,
  input  logic            pf_pte,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            m_we,
  output logic            s_we,
  output logic            vs_we,
  output logic [XLEN-1:0] info_wdata,
  output logic [XLEN-1:0] m_info,
  output logic [XLEN-1:0] s_info,
  output logic [XLEN-1:0] vs_info
);
  logic [NSLOT-1:0] trap_sel;
  logic [NSLOT-1:0] addr_hit;
  logic [NSLOT-1:0] sw_sel;
  logic [XLEN-1:0]  slot_q [NSLOT];

  frr_encode #(.XLEN(XLEN)) u_enc (
    .exc_class (exc_class),
    .flt_type  (flt_type),
    .flt_cause (flt_cause),
    .pf_normal (pf_normal),
    .pf_pte    (pf_pte),
    .value     (info_wdata)
  );

  frr_route #(.ADDR_M(ADDR_M), .ADDR_S(ADDR_S), .ADDR_VS(ADDR_VS)) u_route (
    .trap_valid (trap_valid),
    .trap_mode  (trap_mode),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .trap_sel   (trap_sel),
    .addr_hit   (addr_hit),
    .sw_sel     (sw_sel)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    frr_slot #(.XLEN(XLEN)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .trap_we   (trap_sel[i]),
      .trap_data (info_wdata),
      .sw_we     (sw_sel[i]),
      .sw_data   (csr_wdata),
      .q         (slot_q[i])
    );
  end

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (addr_hit[i]) csr_rdata = slot_q[i];
  end

  assign m_we    = trap_sel[0];
  assign s_we    = trap_sel[1];
  assign vs_we   = trap_sel[2];
  assign m_info  = slot_q[0];
  assign s_info  = slot_q[1];
  assign vs_info = slot_q[2];
endmodule

// File: rtl/cheri_finfo_chk.sv
module cheri_finfo_chk #(
  parameter int          XLEN    = 64,
  parameter logic [11:0] ADDR_M  = 12'h34B
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic [1:0]      trap_mode,
  input logic [1:0]      exc_class,
  input logic            pf_normal,
  input logic            pf_pte,
  input logic            csr_we,
  input logic [11:0]     csr_addr,
  input logic            m_we,
  input logic            s_we,
  input logic            vs_we,
  input logic [XLEN-1:0] info_wdata,
  input logic [XLEN-1:0] m_info
);
  // R1 R2 R3: at most one destination per trap
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_we, s_we, vs_we}));

  // R3: mode code 3 selects nothing
  a_r3_none_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_mode == 2'd3) |-> !(m_we || s_we || vs_we));

  // R1: machine register captures the trap value
  a_r1_m_capture: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |=> m_info == $past(info_wdata));

  // R4: only the two fields may be nonzero for a capability fault
  a_r4_fields_only: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_class == 2'd1) |-> (info_wdata[15:4] == '0 && info_wdata[XLEN-1:20] == '0));

  // R5: both page fault kinds give code 2
  a_r5_pf_both: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_class == 2'd2 && pf_normal && pf_pte) |-> info_wdata == XLEN'(2));

  // R6: unrelated exceptions write zero
  a_r6_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_class == 2'd0 || exc_class == 2'd3) |-> info_wdata == '0);

  // R7: machine register holds when nothing targets it
  a_r7_m_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_we && !(csr_we && csr_addr == ADDR_M)) |=> $stable(m_info));
endmodule

bind cheri_finfo_top cheri_finfo_chk #(.XLEN(XLEN), .ADDR_M(ADDR_M)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_mode  (trap_mode),
  .exc_class  (exc_class),
  .pf_normal  (pf_normal),
  .pf_pte     (pf_pte),
  .csr_we     (csr_we),
  .csr_addr   (csr_addr),
  .m_we       (m_we),
  .s_we       (s_we),
  .vs_we      (vs_we),
  .info_wdata (info_wdata),
  .m_info     (m_info)
);

// File: tb/cheri_finfo_top_tb.sv
module cheri_finfo_top_tb;
  localparam int XLEN = 64;
  localparam logic [11:0] AM = 12'h34B, AS = 12'h14B, AV = 12'h24B;

  logic clk = 0, rst_n = 0;
  logic trap_valid = 0, pf_normal = 0, pf_pte = 0, csr_we = 0;
  logic [1:0] trap_mode = 0, exc_class = 0;
  logic [3:0] flt_type = 0, flt_cause = 0;
  logic [11:0] csr_addr = 0;
  logic [XLEN-1:0] csr_wdata = 0;
  logic [XLEN-1:0] csr_rdata, info_wdata, m_info, s_info, vs_info;
  logic m_we, s_we, vs_we;

  int errors = 0, checks = 0;
  logic [XLEN-1:0] em = 0, es = 0, ev = 0;

  always #2.5 clk = ~clk;

  cheri_finfo_top #(.XLEN(XLEN)) u_dut (.*);

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk({req, " m"},  m_info,  em);
    chk({req, " s"},  s_info,  es);
    chk({req, " vs"}, vs_info, ev);
  endtask

  task automatic idle();
    trap_valid = 0; csr_we = 0; exc_class = 0; trap_mode = 0;
    pf_normal = 0; pf_pte = 0; flt_type = 0; flt_cause = 0;
  endtask

  // drive a trap at a falling edge, check comb outputs, let one rising edge pass
  task automatic trap(input string req, input logic [1:0] mode, input logic [1:0] cls,
                      input logic [3:0] ty, input logic [3:0] ca,
                      input logic pn, input logic pp, input logic [XLEN-1:0] exp_val);
    @(negedge clk);
    trap_valid = 1; trap_mode = mode; exc_class = cls;
    flt_type = ty; flt_cause = ca; pf_normal = pn; pf_pte = pp;
    #1;
    chk({req, " wdata"}, info_wdata, exp_val);
    chk({req, " we"}, XLEN'({m_we, s_we, vs_we}),
        XLEN'(mode == 0 ? 3'b100 : mode == 1 ? 3'b010 : mode == 2 ? 3'b001 : 3'b000));
    case (mode)
      2'd0: em = exp_val;
      2'd1: es = exp_val;
      2'd2: ev = exp_val;
      default: ;
    endcase
    @(negedge clk);
    idle();
    chk_regs(req);
  endtask

  task automatic sw_write(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    if (a == AM) em = d; else if (a == AS) es = d; else if (a == AV) ev = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic sw_read(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1 chk(req, csr_rdata, exp);
  endtask

  initial begin
    #50000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk_regs("R10 reset");
    chk("R10 we", XLEN'({m_we, s_we, vs_we}), '0);
    rst_n = 1;

    // R1 R4: capability fault into machine, type 3 at [19:16], cause 0xA at [3:0]
    trap("R1 R4 cap fault M", 2'd0, 2'd1, 4'h3, 4'hA, 0, 0, 64'h0003_000A);
    // R2 R5: both page fault kinds into supervisor
    trap("R2 R5 pf both S", 2'd1, 2'd2, 4'hF, 4'hF, 1, 1, 64'd2);
    // R3 R5: table-only page fault into virtual supervisor
    trap("R3 R5 pf pte VS", 2'd2, 2'd2, 4'h0, 4'h0, 0, 1, 64'd1);
    // R5: normal-only page fault gives 0, clears machine register
    trap("R5 pf normal M", 2'd0, 2'd2, 4'h1, 4'h2, 1, 0, 64'd0);
    // R4: different codes into supervisor
    trap("R4 cap fault S", 2'd1, 2'd1, 4'hC, 4'h5, 1, 1, 64'h000C_0005);
    // R6: other exception clears supervisor despite fault inputs
    trap("R6 other S", 2'd1, 2'd0, 4'h7, 4'h7, 1, 1, 64'd0);
    // R6: class 3 also treated as other
    trap("R6 class3 VS", 2'd2, 2'd3, 4'h9, 4'h9, 0, 1, 64'd0);
    // R3 R7: mode 3 writes nothing
    trap("R1 seed M", 2'd0, 2'd1, 4'h2, 4'h1, 0, 0, 64'h0002_0001);
    trap("R3 R7 mode3", 2'd3, 2'd1, 4'hE, 4'hE, 0, 0, 64'h000E_000E);

    // R8: software write and read of each register
    sw_write(AM, 64'hDEAD_BEEF_0123_4567);
    sw_write(AS, 64'h1111_2222_3333_4444);
    sw_write(AV, 64'h8000_0000_0000_0001);
    chk_regs("R8 sw write");
    sw_read("R8 read M", AM, em);
    sw_read("R8 read S", AS, es);
    sw_read("R8 read VS", AV, ev);
    sw_read("R8 read other", 12'h343, '0);
    // R7: write to unknown address changes nothing
    sw_write(12'h14C, 64'hFFFF);
    chk_regs("R7 unknown addr");

    // R9: trap and software write to the same register; trap wins
    @(negedge clk);
    trap_valid = 1; trap_mode = 2'd1; exc_class = 2'd1; flt_type = 4'h4; flt_cause = 4'h6;
    csr_we = 1; csr_addr = AS; csr_wdata = 64'h5555;
    es = 64'h0004_0006;
    @(negedge clk);
    idle();
    chk_regs("R9 collision");

    // R2 R8: trap to supervisor while software writes virtual supervisor
    @(negedge clk);
    trap_valid = 1; trap_mode = 2'd1; exc_class = 2'd2; pf_pte = 1;
    csr_we = 1; csr_addr = AV; csr_wdata = 64'h7777;
    es = 64'd1; ev = 64'h7777;
    @(negedge clk);
    idle();
    chk_regs("R2 R8 split");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule